// File: doc/BRIEF.md
# Receive FIFO with Per-Character Error Status

This block buffers characters coming out of a UART receiver. Each character is kept next to its own three error flags (break seen, framing error, parity error), so the flags leave the buffer with the byte they belong to. The receiver state machine pushes a byte and its flags. The host pops bytes from the head and reads a three-bit status view.

Two status views are available. In per-character mode the status follows the entry at the head, so the host reads the status before it pops the byte. In block mode the status is the running OR of the flags of every character accepted since the last error-clear pulse. A receiver-ready output tells the host, or an interrupt arbiter, that the fill level has reached a programmed threshold. Writes that arrive while the buffer is full are discarded and recorded in a sticky overrun flag.

Top module: `rx_status_fifo`

## Requirements
- R1: The buffer holds 16 entries and returns bytes in arrival order. `rd_data` shows the head byte combinationally and advances one cycle after a pop.
- R2: `char_len` selects the character width: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Data bits above the selected width are stored as 0.
- R3: A write while 16 entries are held is dropped, even if a pop happens in the same cycle. The drop sets `overrun`, which stays at 1 until an `err_clear` pulse.
- R4: A pop while the buffer is empty changes nothing. `rd_data` and the per-character status keep showing the most recently popped entry. A later write is then read back normally.
- R5: When `block_mode` is 0, `rx_status` = {break, framing, parity} of the head entry, which is bit 10, bit 9 and bit 8 of the stored entry.
- R6: When `block_mode` is 1, `rx_status` is the OR of the flags of all characters accepted since the last `err_clear`. Pops do not change it. When a write and `err_clear` fall in the same cycle, the accumulator is cleared and then takes that write's flags.
- R7: `thresh_code` sets the ready threshold: 0 = 1 entry, 1 = 4, 2 = 8, 3 = 16. `rx_ready` is 1 exactly when the fill level is at or above the threshold.
- R8: `rx_ready` is 0 whenever the buffer is empty.
- R9: After reset the buffer is empty, and `rx_ready`, `overrun`, `rx_status` and `rd_data` are all 0.
- R10: A push and a pop in the same cycle on a buffer that is neither empty nor full leave the fill level unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_len | input | 2 | Character width code for incoming data |
| wr_en | input | 1 | Push request from the receiver |
| wr_data | input | 8 | Received byte |
| wr_break | input | 1 | Break flag of the received character |
| wr_frame | input | 1 | Framing-error flag of the received character |
| wr_parity | input | 1 | Parity-error flag of the received character |
| rd_en | input | 1 | Pop request from the host |
| block_mode | input | 1 | 1 selects accumulated status, 0 selects per-character status |
| err_clear | input | 1 | Clears the block accumulator and the overrun flag |
| thresh_code | input | 2 | Ready threshold code |
| rd_data | output | 8 | Head byte |
| rx_status | output | 3 | {break, framing, parity} status view |
| rx_ready | output | 1 | Fill level at or above the threshold |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The bench sweeps every threshold code through every fill level from 0 to 16 while filling, and again while draining. This separates off-by-one threshold faults from faults in the code mapping. Each entry carries a data value from an arithmetic pattern and a different flag combination. The drain therefore shows whether the flags stay bound to their own byte, and whether byte order is kept.

Further cases cover:
- a full buffer that receives a marked byte, which must never come out;
- pops on an empty buffer;
- all four character widths;
- block-mode accumulation across pops and a clear that coincides with a write;
- a simultaneous push and pop.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_flags_t;

    typedef struct packed {
        rx_flags_t          flags;
        logic [BYTE_W-1:0]  data;
    } rx_entry_t;

    // Keep only the low (5 + len_code) data bits.
    function automatic logic [BYTE_W-1:0] mask_data(input logic [BYTE_W-1:0] d,
                                                    input logic [1:0] len_code);
        logic [BYTE_W-1:0] m;
        m = {BYTE_W{1'b1}} >> (2'd3 - len_code);
        return d & m;
    endfunction

    // Threshold in entries: 1, quarter, half or full depth.
    function automatic int unsigned level_for_code(input logic [1:0] code,
                                                   input int unsigned depth);
        case (code)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth;
        endcase
    endfunction

endpackage

// File: rtl/rxq_storage.sv
module rxq_storage
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  rx_entry_t        push_entry,
    input  logic             pop_req,
    output rx_entry_t        head_entry,
    output logic [CNT_W-1:0] fill,
    output logic             push_ok,
    output logic             push_drop
);

    rx_entry_t        mem [DEPTH];
    rx_entry_t        last_pop;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop_ok;
    logic             is_full, is_empty;

    assign is_full   = (fill == CNT_W'(DEPTH));
    assign is_empty  = (fill == '0);
    assign push_ok   = push_req && !is_full;
    assign push_drop = push_req && is_full;
    assign pop_ok    = pop_req && !is_empty;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill     <= '0;
            last_pop <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok) begin
                rd_ptr   <= ptr_next(rd_ptr);
                last_pop <= mem[rd_ptr];
            end
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign head_entry = is_empty ? last_pop : mem[rd_ptr];

    // R3: level never passes the depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    // R3: a dropped write without a pop leaves the level alone
    assert_drop_keeps_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (push_drop && !pop_req) |=> (fill == $past(fill)));

    // R4: empty pop with no push moves nothing
    assert_empty_pop_inert_R4: assert property (@(posedge clk) disable iff (rst)
        (is_empty && pop_req && !push_req) |=>
            (rd_ptr == $past(rd_ptr) && head_entry == $past(head_entry)));

    // R10: simultaneous accepted push and pop keep the level
    assert_push_pop_level_R10: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok) |=> (fill == $past(fill)));

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      block_mode,
    input  logic      err_clear,
    input  logic      push_ok,
    input  logic      push_drop,
    input  rx_flags_t push_flags,
    input  rx_flags_t head_flags,
    output rx_flags_t status_view,
    output logic      overrun
);

    rx_flags_t acc;
    rx_flags_t acc_base;
    rx_flags_t acc_add;

    always_comb begin
        acc_base = err_clear ? rx_flags_t'('0) : acc;
        acc_add  = push_ok ? push_flags : rx_flags_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            overrun <= 1'b0;
        end else begin
            acc <= acc_base | acc_add;
            if (push_drop)      overrun <= 1'b1;
            else if (err_clear) overrun <= 1'b0;
        end
    end

    assign status_view = block_mode ? acc : head_flags;

    // R3: overrun stays set until cleared
    assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (overrun && !err_clear) |=> overrun);

    // R6: accumulated flags never drop without a clear
    assert_acc_monotonic_R6: assert property (@(posedge clk) disable iff (rst)
        !err_clear |=> ((acc & $past(acc)) == $past(acc)));

endmodule

// File: rtl/rxq_ready.sv
module rxq_ready
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       thresh_code,
    input  logic [CNT_W-1:0] fill,
    output logic             rx_ready
);

    logic [CNT_W-1:0] level;

    assign level    = CNT_W'(level_for_code(thresh_code, DEPTH));
    assign rx_ready = (fill >= level);

    // R8: an empty buffer never requests service
    assert_empty_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |-> !rx_ready);

endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  char_len,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        wr_break,
    input  logic        wr_frame,
    input  logic        wr_parity,
    input  logic        rd_en,
    input  logic        block_mode,
    input  logic        err_clear,
    input  logic [1:0]  thresh_code,
    output logic [7:0]  rd_data,
    output logic [2:0]  rx_status,
    output logic        rx_ready,
    output logic        overrun
);

    rx_entry_t        in_entry;
    rx_entry_t        head;
    rx_flags_t        view;
    logic [CNT_W-1:0] fill;
    logic             push_ok, push_drop;

    always_comb begin
        in_entry.flags.brk = wr_break;
        in_entry.flags.frm = wr_frame;
        in_entry.flags.par = wr_parity;
        in_entry.data      = mask_data(wr_data, char_len);
    end

    rxq_storage #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push_req   (wr_en),
        .push_entry (in_entry),
        .pop_req    (rd_en),
        .head_entry (head),
        .fill       (fill),
        .push_ok    (push_ok),
        .push_drop  (push_drop)
    );

    rxq_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .block_mode  (block_mode),
        .err_clear   (err_clear),
        .push_ok     (push_ok),
        .push_drop   (push_drop),
        .push_flags  (in_entry.flags),
        .head_flags  (head.flags),
        .status_view (view),
        .overrun     (overrun)
    );

    rxq_ready #(.DEPTH(DEPTH)) u_rdy (
        .clk         (clk),
        .rst         (rst),
        .thresh_code (thresh_code),
        .fill        (fill),
        .rx_ready    (rx_ready)
    );

    assign rd_data   = head.data;
    assign rx_status = view;

    // R3: a dropped write always leaves overrun set on the next cycle
    assert_drop_flags_overrun_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !push_ok) |=> overrun);

endmodule

// File: tb/rx_status_fifo_tb.sv
module rx_status_fifo_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] char_len = 2'd3;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_break = 1'b0, wr_frame = 1'b0, wr_parity = 1'b0;
    logic       rd_en = 1'b0;
    logic       block_mode = 1'b0;
    logic       err_clear = 1'b0;
    logic [1:0] thresh_code = 2'd0;
    logic [7:0] rd_data;
    logic [2:0] rx_status;
    logic       rx_ready, overrun;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rx_status_fifo u_dut (
        .clk(clk), .rst(rst), .char_len(char_len), .wr_en(wr_en), .wr_data(wr_data),
        .wr_break(wr_break), .wr_frame(wr_frame), .wr_parity(wr_parity),
        .rd_en(rd_en), .block_mode(block_mode), .err_clear(err_clear),
        .thresh_code(thresh_code), .rd_data(rd_data), .rx_status(rx_status),
        .rx_ready(rx_ready), .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] f);
        wr_en = 1'b1;
        wr_data = d;
        {wr_break, wr_frame, wr_parity} = f;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic clr();
        err_clear = 1'b1;
        cyc();
        err_clear = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int c, input int n);
        return 8'((n * 29 + c * 71 + 3) & 255);
    endfunction

    function automatic int thr(input int c);
        return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R9: reset state
        chk("R9 ready", rx_ready, 0);
        chk("R9 overrun", overrun, 0);
        chk("R9 status", rx_status, 0);
        chk("R9 data", rd_data, 0);

        // R7/R8/R1/R5: sweep every threshold code over every fill level
        for (int c = 0; c < 4; c++) begin
            thresh_code = 2'(c);
            #1;
            chk("R8 empty ready", rx_ready, 0);
            for (int n = 1; n <= 16; n++) begin
                push(pat(c, n), 3'(n % 8));
                chk("R7 fill ready", rx_ready, (n >= thr(c)) ? 1 : 0);
            end
            for (int n = 1; n <= 16; n++) begin
                chk("R1 order", rd_data, pat(c, n));
                chk("R5 head flags", rx_status, n % 8);
                pop();
                chk("R7 drain ready", rx_ready,
                    ((16 - n) >= thr(c) && (16 - n) > 0) ? 1 : 0);
            end
        end

        // R3: overrun and dropped write
        thresh_code = 2'd3;
        for (int n = 1; n <= 16; n++) push(pat(0, n), 3'(n % 8));
        chk("R3 overrun before", overrun, 0);
        push(8'hEE, 3'd7);
        chk("R3 overrun set", overrun, 1);
        chk("R3 still full", rx_ready, 1);
        for (int n = 1; n <= 16; n++) begin
            chk("R3 no marked byte", rd_data, pat(0, n));
            pop();
        end
        chk("R3 drained ready", rx_ready, 0);
        chk("R3 sticky", overrun, 1);

        // R4: pop on empty
        pop();
        chk("R4 empty data", rd_data, pat(0, 16));
        chk("R4 empty flags", rx_status, 0);
        pop();
        chk("R4 empty data again", rd_data, pat(0, 16));
        clr();
        chk("R3 cleared", overrun, 0);
        push(8'h5A, 3'd3);
        chk("R4 next data", rd_data, 8'h5A);
        chk("R4 next flags", rx_status, 3);
        pop();

        // R2: character width masking
        for (int l = 0; l < 4; l++) begin
            char_len = 2'(l);
            push(8'hFF, 3'd0);
            chk("R2 mask", rd_data, 255 >> (3 - l));
            pop();
            push(8'hB6, 3'd0);
            chk("R2 mask pattern", rd_data, 8'hB6 & (255 >> (3 - l)));
            pop();
        end
        char_len = 2'd3;

        // R6: block mode accumulation
        clr();
        block_mode = 1'b1;
        #1;
        chk("R6 after clear", rx_status, 0);
        push(8'd11, 3'b001);
        chk("R6 one flag", rx_status, 1);
        push(8'd22, 3'b010);
        chk("R6 two flags", rx_status, 3);
        pop();
        chk("R6 pop keeps", rx_status, 3);
        pop();
        chk("R6 empty keeps", rx_status, 3);
        err_clear = 1'b1;
        push(8'd33, 3'b100);
        err_clear = 1'b0;
        chk("R6 clear with write", rx_status, 4);
        block_mode = 1'b0;
        #1;
        chk("R5 head after mode", rx_status, 4);
        chk("R5 head data", rd_data, 33);
        pop();

        // R10: push and pop together
        thresh_code = 2'd1;
        push(8'd101, 3'd0);
        push(8'd102, 3'd1);
        push(8'd103, 3'd2);
        chk("R10 three held", rx_ready, 0);
        rd_en = 1'b1;
        push(8'd104, 3'd3);
        rd_en = 1'b0;
        chk("R10 level same", rx_ready, 0);
        chk("R10 head moved", rd_data, 102);
        push(8'd105, 3'd4);
        chk("R10 four held", rx_ready, 1);
        for (int k = 102; k <= 105; k++) begin
            chk("R10 order", rd_data, k);
            pop();
        end
        chk("R8 empty end", rx_ready, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule